// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block translates the addresses of a single DMA master from virtual to physical pages. Pages are 4 KiB. The translation table is one flat array of 32-bit words in memory, one word per virtual page of a programmable window. Each word holds the physical page number for that page. A small fully associative TLB keeps the most recent translations. When a lookup misses, the block reads the missing word over a simple read port, stalls the master until the word arrives, installs it and answers.

Software programs the table base page, the window (first virtual page and page span) and two protection pages, one for reads and one for writes. It does this through a small word-addressed register port. Any access that falls outside the window, or whose table word is zero, goes to the protection page for its direction; the response is flagged and a sticky fault flag is set. A write of any value to the update register empties the TLB, and software issues it after it edits the table. Clearing the enable bit or setting the bypass bit makes addresses pass through unchanged.

The controller has three states:
- ST_IDLE accepts requests.
- ST_FETCH holds a table read request until the memory takes it.
- ST_WAIT waits for the table word.

The transitions are:
- ST_IDLE goes to ST_FETCH on an in-window TLB miss.
- ST_FETCH goes to ST_WAIT when `mem_req_ready` is high.
- ST_WAIT goes to ST_IDLE when `mem_rsp_valid` is high.

Every other request is answered from ST_IDLE, and the block stays there.

Top module: `flat_xlat`

## Requirements
- R1: The low 12 bits of the request address appear unchanged in `rsp_addr`. A translated address is {table word bits 19:0, offset}.
- R2: On a miss, the table read address is (table base page << 12) + 4 × (request page − window first page).
- R3: A page lies in the window when it is ≥ first page and (page − first page) ≤ span. After reset, first page is 0 and span is 0xFFFF, which covers 256 MiB from address 0. A page outside the window is answered with the protection page, `rsp_fault` = 1 and no table read.
- R4: Faulting reads use the read protection page (offset 0x14). Faulting writes (`req_write` = 1) use the write protection page (offset 0x18).
- R5: A table word of zero means the page is unmapped. The access goes to the protection page for its direction with `rsp_fault` = 1. Every faulting response sets `fault_sticky`.
- R6: In the config register (offset 0x04), bit 0 enables translation, bit 1 is a clock-gate enable that is only stored and read back, and bit 4 selects bypass. With bit 0 clear or bit 4 set, `rsp_addr` equals `req_addr`, `rsp_fault` = 0 and no table read is issued.
- R7: Writing any value to the update register (offset 0x08) invalidates every TLB entry and clears `fault_sticky`. A fill that arrives in the same cycle as that write is dropped, but its response is still delivered. A fault in the same cycle as the write still sets the flag.
- R8: The version register (offset 0x00) reads the version code (default 0x01) in bits 15:8 and zero elsewhere. Writes to it have no effect.
- R9: The TLB has 4 entries, filled round robin in fill order. The fifth distinct page replaces the oldest fill, and later lookups of that page fetch again.
- R10: At most one table read is outstanding. `req_ready` stays low from the acceptance of a miss until its response. `mem_req_valid` and `mem_req_addr` hold until `mem_req_ready`.
- R11: `rsp_valid` pulses one cycle after acceptance for hits, faults and pass-through, and one cycle after `mem_rsp_valid` for misses.
- R12: The table base (0x10), read protection page (0x14), write protection page (0x18), first page (0x1C) and span (0x20) registers each hold 20 bits. Each reads back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for `cfg_addr` |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 for a write access |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 32 | Physical address |
| rsp_fault | output | 1 | Response was redirected to a protection page |
| fault_sticky | output | 1 | Sticky fault flag |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the table read |
| mem_req_addr | output | 32 | Table word byte address |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 32 | Table word |

## Verification
The interesting coincidence is an update-register write that lands in the same cycle as a table word arriving in ST_WAIT. Invalidation and refill then both target the TLB at one edge. The bench provokes this by driving the update write together with `mem_rsp_valid`. It judges the result in two ways. The response must still carry the fetched translation. A second access to the same page must issue a new table read, which shows the fill was dropped. The same cycle also shows that the sticky flag was cleared rather than left set.

// File: rtl/flat_xlat_pkg.sv
package flat_xlat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_WAIT  = 2'd2
    } xl_state_e;

    localparam logic [7:0] OFS_VERSION   = 8'h00;
    localparam logic [7:0] OFS_CONFIG    = 8'h04;
    localparam logic [7:0] OFS_UPDATE    = 8'h08;
    localparam logic [7:0] OFS_TBL_BASE  = 8'h10;
    localparam logic [7:0] OFS_DEF_RD    = 8'h14;
    localparam logic [7:0] OFS_DEF_WR    = 8'h18;
    localparam logic [7:0] OFS_WIN_FIRST = 8'h1C;
    localparam logic [7:0] OFS_WIN_SPAN  = 8'h20;

    localparam int CFG_EN_BIT   = 0;
    localparam int CFG_GATE_BIT = 1;
    localparam int CFG_BYP_BIT  = 4;

endpackage

// File: rtl/xlat_regs.sv
module xlat_regs
    import flat_xlat_pkg::*;
#(
    parameter int          AW            = 32,
    parameter int          PB            = 12,
    parameter int          DW            = 32,
    parameter int          RAW           = 8,
    parameter logic [7:0]  VER_CODE      = 8'h01,
    parameter int          WIN_RST_PAGES = 65536
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [RAW-1:0]       cfg_addr,
    input  logic [DW-1:0]        cfg_wdata,
    output logic [DW-1:0]        cfg_rdata,
    output logic                 xl_en,
    output logic                 bypass,
    output logic [AW-PB-1:0]     tbl_ppn,
    output logic [AW-PB-1:0]     def_rd_ppn,
    output logic [AW-PB-1:0]     def_wr_ppn,
    output logic [AW-PB-1:0]     win_first,
    output logic [AW-PB-1:0]     win_span,
    output logic                 flush
);
    localparam int VPN_W = AW - PB;
    localparam logic [VPN_W-1:0] SPAN_RST = VPN_W'(WIN_RST_PAGES - 1);

    logic en_q, gate_q, byp_q;
    logic [VPN_W-1:0] tbl_q, drd_q, dwr_q, first_q, span_q;
    logic unused_wdata;

    assign unused_wdata = ^cfg_wdata[DW-1:VPN_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            gate_q  <= 1'b0;
            byp_q   <= 1'b0;
            tbl_q   <= '0;
            drd_q   <= '0;
            dwr_q   <= '0;
            first_q <= '0;
            span_q  <= SPAN_RST;
        end else if (cfg_we) begin
            case (cfg_addr)
                RAW'(OFS_CONFIG): begin
                    en_q   <= cfg_wdata[CFG_EN_BIT];
                    gate_q <= cfg_wdata[CFG_GATE_BIT];
                    byp_q  <= cfg_wdata[CFG_BYP_BIT];
                end
                RAW'(OFS_TBL_BASE):  tbl_q   <= cfg_wdata[VPN_W-1:0];
                RAW'(OFS_DEF_RD):    drd_q   <= cfg_wdata[VPN_W-1:0];
                RAW'(OFS_DEF_WR):    dwr_q   <= cfg_wdata[VPN_W-1:0];
                RAW'(OFS_WIN_FIRST): first_q <= cfg_wdata[VPN_W-1:0];
                RAW'(OFS_WIN_SPAN):  span_q  <= cfg_wdata[VPN_W-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_addr)
            RAW'(OFS_VERSION):   cfg_rdata[15:8] = VER_CODE;
            RAW'(OFS_CONFIG): begin
                cfg_rdata[CFG_EN_BIT]   = en_q;
                cfg_rdata[CFG_GATE_BIT] = gate_q;
                cfg_rdata[CFG_BYP_BIT]  = byp_q;
            end
            RAW'(OFS_TBL_BASE):  cfg_rdata = DW'(tbl_q);
            RAW'(OFS_DEF_RD):    cfg_rdata = DW'(drd_q);
            RAW'(OFS_DEF_WR):    cfg_rdata = DW'(dwr_q);
            RAW'(OFS_WIN_FIRST): cfg_rdata = DW'(first_q);
            RAW'(OFS_WIN_SPAN):  cfg_rdata = DW'(span_q);
            default:             cfg_rdata = '0;
        endcase
    end

    assign xl_en      = en_q;
    assign bypass     = byp_q;
    assign tbl_ppn    = tbl_q;
    assign def_rd_ppn = drd_q;
    assign def_wr_ppn = dwr_q;
    assign win_first  = first_q;
    assign win_span   = span_q;
    assign flush      = cfg_we && (cfg_addr == RAW'(OFS_UPDATE));

    AST_VERSION_CONST: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == RAW'(OFS_VERSION)) |=> $stable({en_q, byp_q, tbl_q, span_q})); // R8

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
    parameter int DEPTH = 4,
    parameter int VPN_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [VPN_W-1:0] hit_ppn,
    output logic             hit_mapped,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [VPN_W-1:0] fill_ppn,
    input  logic             fill_mapped,
    input  logic             flush
);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

    logic [IW-1:0]    victim_q;
    logic [DEPTH-1:0] match;
    logic [VPN_W-1:0] way_ppn [DEPTH];
    logic             way_map [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_way
        logic             vld_q;
        logic             map_q;
        logic [VPN_W-1:0] tag_q;
        logic [VPN_W-1:0] ppn_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                vld_q <= 1'b0;
                map_q <= 1'b0;
                tag_q <= '0;
                ppn_q <= '0;
            end else if (flush) begin
                vld_q <= 1'b0;
            end else if (fill_en && victim_q == IW'(g)) begin
                vld_q <= 1'b1;
                map_q <= fill_mapped;
                tag_q <= fill_vpn;
                ppn_q <= fill_ppn;
            end
        end

        assign match[g]   = vld_q && (tag_q == lk_vpn);
        assign way_ppn[g] = ppn_q;
        assign way_map[g] = map_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            victim_q <= '0;
        end else if (fill_en && !flush) begin
            victim_q <= (victim_q == LAST) ? '0 : victim_q + 1'b1;
        end
    end

    always_comb begin
        hit        = |match;
        hit_ppn    = '0;
        hit_mapped = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit_ppn    = hit_ppn | way_ppn[i];
                hit_mapped = hit_mapped | way_map[i];
            end
        end
    end

    AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match)); // R9

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit); // R7

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
    import flat_xlat_pkg::*;
#(
    parameter int AW = 32,
    parameter int PB = 12,
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_write,
    output logic             rsp_valid,
    output logic [AW-1:0]    rsp_addr,
    output logic             rsp_fault,
    output logic             fault_sticky,
    output logic             mem_req_valid,
    input  logic             mem_req_ready,
    output logic [AW-1:0]    mem_req_addr,
    input  logic             mem_rsp_valid,
    input  logic [DW-1:0]    mem_rsp_data,
    input  logic             xl_en,
    input  logic             bypass,
    input  logic [AW-PB-1:0] tbl_ppn,
    input  logic [AW-PB-1:0] def_rd_ppn,
    input  logic [AW-PB-1:0] def_wr_ppn,
    input  logic [AW-PB-1:0] win_first,
    input  logic [AW-PB-1:0] win_span,
    input  logic             flush,
    output logic [AW-PB-1:0] lk_vpn,
    input  logic             tlb_hit,
    input  logic [AW-PB-1:0] tlb_ppn,
    input  logic             tlb_mapped,
    output logic             fill_en,
    output logic [AW-PB-1:0] fill_vpn,
    output logic [AW-PB-1:0] fill_ppn,
    output logic             fill_mapped
);
    localparam int VPN_W = AW - PB;

    xl_state_e state_q, state_d;

    logic [VPN_W-1:0] pend_vpn_q, pend_idx_q;
    logic [PB-1:0]    pend_off_q;
    logic             pend_wr_q, capture;
    logic             rsp_v_q, rsp_v_d;
    logic [AW-1:0]    rsp_a_q, rsp_a_d;
    logic             rsp_f_q, rsp_f_d;
    logic             sticky_q;

    logic [VPN_W-1:0] vpn, rel, def_ppn, pend_def;
    logic [PB-1:0]    off;
    logic             in_win, passthru, entry_ok;

    assign vpn      = req_addr[AW-1:PB];
    assign off      = req_addr[PB-1:0];
    assign rel      = vpn - win_first;
    assign in_win   = (vpn >= win_first) && (rel <= win_span);
    assign passthru = bypass || !xl_en;
    assign def_ppn  = req_write ? def_wr_ppn : def_rd_ppn;
    assign pend_def = pend_wr_q ? def_wr_ppn : def_rd_ppn;
    assign entry_ok = |mem_rsp_data;

    // State and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            pend_vpn_q <= '0;
            pend_idx_q <= '0;
            pend_off_q <= '0;
            pend_wr_q  <= 1'b0;
            rsp_v_q    <= 1'b0;
            rsp_a_q    <= '0;
            rsp_f_q    <= 1'b0;
            sticky_q   <= 1'b0;
        end else begin
            state_q  <= state_d;
            rsp_v_q  <= rsp_v_d;
            rsp_a_q  <= rsp_a_d;
            rsp_f_q  <= rsp_f_d;
            sticky_q <= (sticky_q && !flush) || (rsp_v_d && rsp_f_d);
            if (capture) begin
                pend_vpn_q <= vpn;
                pend_idx_q <= rel;
                pend_off_q <= off;
                pend_wr_q  <= req_write;
            end
        end
    end

    // Next state and outputs
    always_comb begin
        state_d       = state_q;
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        capture       = 1'b0;
        fill_en       = 1'b0;
        rsp_v_d       = 1'b0;
        rsp_a_d       = rsp_a_q;
        rsp_f_d       = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    rsp_v_d = 1'b1;
                    if (passthru) begin
                        rsp_a_d = req_addr;
                    end else if (!in_win) begin
                        rsp_a_d = {def_ppn, off};
                        rsp_f_d = 1'b1;
                    end else if (tlb_hit) begin
                        rsp_a_d = tlb_mapped ? {tlb_ppn, off} : {def_ppn, off};
                        rsp_f_d = !tlb_mapped;
                    end else begin
                        rsp_v_d = 1'b0;
                        capture = 1'b1;
                        state_d = ST_FETCH;
                    end
                end
            end
            ST_FETCH: begin
                mem_req_valid = 1'b1;
                if (mem_req_ready) state_d = ST_WAIT;
            end
            ST_WAIT: begin
                if (mem_rsp_valid) begin
                    fill_en = !flush;
                    rsp_v_d = 1'b1;
                    rsp_a_d = entry_ok ? {mem_rsp_data[VPN_W-1:0], pend_off_q}
                                       : {pend_def, pend_off_q};
                    rsp_f_d = !entry_ok;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign mem_req_addr = {tbl_ppn, {PB{1'b0}}} + (AW'(pend_idx_q) << 2);
    assign lk_vpn       = vpn;
    assign fill_vpn     = pend_vpn_q;
    assign fill_ppn     = mem_rsp_data[VPN_W-1:0];
    assign fill_mapped  = entry_ok;
    assign rsp_valid    = rsp_v_q;
    assign rsp_addr     = rsp_a_q;
    assign rsp_fault    = rsp_f_q;
    assign fault_sticky = sticky_q;

    AST_STALL_ON_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready); // R10

    AST_MEMREQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

    AST_FETCH_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_valid) |-> $past(req_valid && req_ready)); // R10

    AST_PASSTHRU: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && (bypass || !xl_en)) |=>
            (rsp_valid && !rsp_fault && rsp_addr == $past(req_addr))); // R6

    AST_OFFSET_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && tlb_hit) |=>
            (rsp_valid && rsp_addr[PB-1:0] == $past(req_addr[PB-1:0]))); // R1

    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> fault_sticky); // R5

endmodule

// File: rtl/flat_xlat.sv
module flat_xlat #(
    parameter int         AW            = 32,
    parameter int         PB            = 12,
    parameter int         DW            = 32,
    parameter int         RAW           = 8,
    parameter int         TLB_DEPTH     = 4,
    parameter logic [7:0] VER_CODE      = 8'h01,
    parameter int         WIN_RST_PAGES = 65536
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cfg_we,
    input  logic [RAW-1:0] cfg_addr,
    input  logic [DW-1:0]  cfg_wdata,
    output logic [DW-1:0]  cfg_rdata,
    input  logic           req_valid,
    output logic           req_ready,
    input  logic [AW-1:0]  req_addr,
    input  logic           req_write,
    output logic           rsp_valid,
    output logic [AW-1:0]  rsp_addr,
    output logic           rsp_fault,
    output logic           fault_sticky,
    output logic           mem_req_valid,
    input  logic           mem_req_ready,
    output logic [AW-1:0]  mem_req_addr,
    input  logic           mem_rsp_valid,
    input  logic [DW-1:0]  mem_rsp_data
);
    localparam int VPN_W = AW - PB;

    logic             xl_en, bypass, flush;
    logic [VPN_W-1:0] tbl_ppn, def_rd_ppn, def_wr_ppn, win_first, win_span;
    logic [VPN_W-1:0] lk_vpn, tlb_ppn, fill_vpn, fill_ppn;
    logic             tlb_hit, tlb_mapped, fill_en, fill_mapped;

    xlat_regs #(
        .AW(AW), .PB(PB), .DW(DW), .RAW(RAW),
        .VER_CODE(VER_CODE), .WIN_RST_PAGES(WIN_RST_PAGES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xl_en(xl_en), .bypass(bypass),
        .tbl_ppn(tbl_ppn), .def_rd_ppn(def_rd_ppn), .def_wr_ppn(def_wr_ppn),
        .win_first(win_first), .win_span(win_span), .flush(flush)
    );

    xlat_tlb #(.DEPTH(TLB_DEPTH), .VPN_W(VPN_W)) u_tlb (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .hit(tlb_hit), .hit_ppn(tlb_ppn), .hit_mapped(tlb_mapped),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn),
        .fill_mapped(fill_mapped), .flush(flush)
    );

    xlat_ctrl #(.AW(AW), .PB(PB), .DW(DW)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .fault_sticky(fault_sticky),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .xl_en(xl_en), .bypass(bypass), .tbl_ppn(tbl_ppn),
        .def_rd_ppn(def_rd_ppn), .def_wr_ppn(def_wr_ppn),
        .win_first(win_first), .win_span(win_span), .flush(flush),
        .lk_vpn(lk_vpn), .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .tlb_mapped(tlb_mapped),
        .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_ppn(fill_ppn), .fill_mapped(fill_mapped)
    );

endmodule

// File: tb/flat_xlat_tb_top.sv
module flat_xlat_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_addr;
    logic        rsp_fault;
    logic        fault_sticky;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;

    int checks = 0;
    int fails  = 0;
    logic [31:0] last_maddr;
    int          last_lat;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    flat_xlat dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
        .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
        .fault_sticky(fault_sticky),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    localparam logic [31:0] TBASE = 32'h8000_0000;
    localparam logic [19:0] DRD   = 20'h11111;
    localparam logic [19:0] DWR   = 20'h22222;

    function automatic logic [31:0] tbl_val(input logic [31:0] maddr);
        int k;
        k = int'(maddr[17:2]);
        return (k % 7 == 3) ? 32'h0 : 32'(k * 3 + 256);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        chk(tag, cfg_rdata, exp);
    endtask

    task automatic xlat(input string tag, input logic [31:0] va, input logic wr,
                        input logic [31:0] exp_pa, input logic exp_flt, input logic exp_fetch,
                        input int dly, input bit flush_fill);
        bit fetched;
        fetched = 1'b0; last_maddr = '0; last_lat = 0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = va; req_write = wr;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (!rsp_valid && last_lat < 40) begin
            if (mem_req_valid) begin
                fetched = 1'b1;
                last_maddr = mem_req_addr;
                for (int d = 0; d < dly; d++) begin
                    @(negedge clk);
                    chk({tag, " R10 hold"}, {mem_req_valid, mem_req_addr[30:0]},
                        {1'b1, last_maddr[30:0]});
                end
                mem_req_ready = 1'b1;
                @(negedge clk);
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = tbl_val(last_maddr);
                if (flush_fill) begin
                    cfg_we = 1'b1; cfg_addr = 8'h08; cfg_wdata = 32'hFFFF_FFFF;
                end
                chk({tag, " R10 stall"}, 32'(req_ready), 32'd0);
                @(negedge clk);
                mem_rsp_valid = 1'b0;
                cfg_we = 1'b0;
                chk({tag, " R11 miss latency"}, 32'(rsp_valid), 32'd1);
            end else begin
                @(negedge clk);
                last_lat++;
            end
        end
        chk({tag, " addr"}, rsp_addr, exp_pa);
        chk({tag, " fault"}, 32'(rsp_fault), 32'(exp_flt));
        chk({tag, " fetch"}, 32'(fetched), 32'(exp_fetch));
    endtask

    function automatic logic [31:0] va_of(input int idx, input logic [11:0] off);
        return {32'(20'h00100 + idx)} << 12 | 32'(off);
    endfunction

    function automatic logic [31:0] exp_of(input int idx, input logic [11:0] off, input logic wr);
        logic [31:0] e;
        e = tbl_val(TBASE + 32'(4 * idx));
        if (e == 0) return {wr ? DWR : DRD, off};
        return {e[19:0], off};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL R10 watchdog act=timeout exp=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] off;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R10 reset ready", 32'(req_ready), 32'd1);
        chk("R11 reset rsp", 32'(rsp_valid), 32'd0);
        chk("R10 reset memreq", 32'(mem_req_valid), 32'd0);
        chk("R5 reset sticky", 32'(fault_sticky), 32'd0);
        rd_chk("R8 version", 8'h00, 32'h0000_0100);
        rd_chk("R6 config reset", 8'h04, 32'h0);
        rd_chk("R3 span reset", 8'h20, 32'h0000_FFFF);
        rd_chk("R3 first reset", 8'h1C, 32'h0);

        // R6 disabled: pass-through
        xlat("R6 disabled pass", 32'h1234_5678, 1'b0, 32'h1234_5678, 1'b0, 1'b0, 0, 1'b0);
        xlat("R6 disabled pass wr", 32'hFFFF_F001, 1'b1, 32'hFFFF_F001, 1'b0, 1'b0, 0, 1'b0);

        // R3 reset window
        wr_reg(8'h10, 32'h0008_0000);
        wr_reg(8'h14, 32'(DRD));
        wr_reg(8'h18, 32'(DWR));
        wr_reg(8'h04, 32'h3);
        xlat("R3 window top", 32'h0FFF_F123, 1'b0, 32'h300F_D123, 1'b0, 1'b1, 0, 1'b0);
        chk("R2 top entry addr", last_maddr, 32'h8003_FFFC);
        xlat("R3 above reset window", 32'h1000_0456, 1'b0, 32'h1111_1456, 1'b1, 1'b0, 0, 1'b0);
        chk("R5 sticky set", 32'(fault_sticky), 32'd1);
        wr_reg(8'h08, 32'h0);
        chk("R7 sticky cleared", 32'(fault_sticky), 32'd0);

        // reprogram window
        wr_reg(8'h04, 32'h0);
        wr_reg(8'h1C, 32'h0000_0100);
        wr_reg(8'h20, 32'h0000_003F);
        wr_reg(8'h04, 32'h3);
        rd_chk("R12 tbl base", 8'h10, 32'h0008_0000);
        rd_chk("R12 def rd", 8'h14, 32'(DRD));
        rd_chk("R12 def wr", 8'h18, 32'(DWR));
        rd_chk("R12 first", 8'h1C, 32'h100);
        rd_chk("R12 span", 8'h20, 32'h3F);
        rd_chk("R6 config", 8'h04, 32'h3);

        // sweep the window: every page misses once
        for (int i = 0; i < 64; i++) begin
            off = 12'((i * 37) & 12'hFFF);
            xlat("R1 sweep", va_of(i, off), 1'b0, exp_of(i, off, 1'b0),
                 tbl_val(TBASE + 32'(4 * i)) == 0, 1'b1, i % 3, 1'b0);
            chk("R2 sweep entry addr", last_maddr, TBASE + 32'(4 * i));
        end

        // hits on the four most recent fills
        for (int i = 60; i < 64; i++) begin
            xlat("R9 recent hit", va_of(i, 12'hABC), 1'b1, exp_of(i, 12'hABC, 1'b1), 1'b0, 1'b0, 0, 1'b0);
            chk("R11 hit latency", 32'(last_lat), 32'd0);
        end

        // round robin replacement
        xlat("R9 new page", va_of(5, 12'h005), 1'b0, exp_of(5, 12'h005, 1'b0), 1'b0, 1'b1, 0, 1'b0);
        xlat("R9 survivor hit", va_of(61, 12'h061), 1'b0, exp_of(61, 12'h061, 1'b0), 1'b0, 1'b0, 0, 1'b0);
        xlat("R9 evicted refetch", va_of(60, 12'h060), 1'b0, exp_of(60, 12'h060, 1'b0), 1'b0, 1'b1, 0, 1'b0);
        xlat("R9 second evict", va_of(61, 12'h061), 1'b0, exp_of(61, 12'h061, 1'b0), 1'b0, 1'b1, 0, 1'b0);
        xlat("R9 still hit", va_of(63, 12'h063), 1'b0, exp_of(63, 12'h063, 1'b0), 1'b0, 1'b0, 0, 1'b0);

        // out of window, both directions
        xlat("R3 R4 below window rd", 32'h000F_FABC, 1'b0, 32'h1111_1ABC, 1'b1, 1'b0, 0, 1'b0);
        xlat("R3 R4 above window wr", 32'h0014_0DEF, 1'b1, 32'h2222_2DEF, 1'b1, 1'b0, 0, 1'b0);
        xlat("R3 last page inside", 32'h0013_F777, 1'b0, 32'h001B_D777, 1'b0, 1'b0, 0, 1'b0);
        chk("R5 sticky after window faults", 32'(fault_sticky), 32'd1);

        // flush
        wr_reg(8'h08, 32'h1234);
        chk("R7 flush clears sticky", 32'(fault_sticky), 32'd0);
        xlat("R7 refetch after flush", va_of(63, 12'h001), 1'b0, exp_of(63, 12'h001, 1'b0), 1'b0, 1'b1, 0, 1'b0);

        // zero entry, write direction
        xlat("R5 R4 unmapped wr", va_of(10, 12'h3A0), 1'b1, {DWR, 12'h3A0}, 1'b1, 1'b1, 1, 1'b0);
        chk("R5 sticky unmapped", 32'(fault_sticky), 32'd1);
        xlat("R5 unmapped rd hit", va_of(10, 12'h3A1), 1'b0, {DRD, 12'h3A1}, 1'b1, 1'b0, 0, 1'b0);

        // flush coincident with fill
        xlat("R7 flush at fill", va_of(20, 12'h020), 1'b0, exp_of(20, 12'h020, 1'b0), 1'b0, 1'b1, 0, 1'b1);
        chk("R7 flush at fill sticky", 32'(fault_sticky), 32'd0);
        xlat("R7 fill dropped", va_of(20, 12'h021), 1'b0, exp_of(20, 12'h021, 1'b0), 1'b0, 1'b1, 0, 1'b0);

        // bypass and enable clear
        wr_reg(8'h04, 32'h13);
        rd_chk("R6 config bypass", 8'h04, 32'h13);
        xlat("R6 bypass", va_of(3, 12'h777), 1'b0, va_of(3, 12'h777), 1'b0, 1'b0, 0, 1'b0);
        wr_reg(8'h04, 32'h2);
        rd_chk("R6 gate only", 8'h04, 32'h2);
        xlat("R6 enable clear", 32'h0014_0001, 1'b1, 32'h0014_0001, 1'b0, 1'b0, 0, 1'b0);

        // version is read only
        wr_reg(8'h00, 32'hFFFF_FFFF);
        rd_chk("R8 version after write", 8'h00, 32'h0000_0100);
        rd_chk("R8 config unaffected", 8'h04, 32'h2);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule